// File: doc/BRIEF.md
# Memory-Mapped I/O Address Decoder

This block joins an 8-bit processor bus to two targets: a 256-byte byte-wide synchronous RAM, which the block contains, and a small I/O port that drives LEDs and reads a bank of switches. The two most significant address bits pick the target. The value 2'b11 selects the I/O port, which covers addresses 0xC0 to 0xFF. The other three values select RAM, which covers 0x00 to 0xBF.

A write changes only the target whose range holds the address. Reads take one clock. On an enabled cycle the RAM registers the word at the given address, and the block samples the switches and registers the region decision at the same edge. The output multiplexer uses that registered decision, so the returned byte always comes from the source the address pointed at when the read was issued. The RAM behaves read-first: on a write cycle its output shows the value the location held before the write. When the enable is low, nothing changes and the read output holds its value.

Top module: `mmio_bus_decoder`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `led_out` is 0x00 and `rdata` is 0x00.
- R2: A cycle with `bus_en`=1, `bus_we`=1 and `addr[7:6]` not equal to 2'b11 stores `wdata` at RAM location `addr`. A later enabled read of that address returns the value.
- R3: A cycle with `bus_en`=1, `bus_we`=1 and `addr[7:6]`=2'b11 loads `wdata` into `led_out` at that clock edge. It writes no RAM location.
- R4: An enabled write whose `addr[7:6]` is not 2'b11 leaves `led_out` unchanged.
- R5: An enabled cycle with `addr[7:6]`=2'b11 presents on `rdata` the value `sw_in` had at that clock edge, starting one cycle later.
- R6: The RAM is read-first. After an enabled write to RAM, the next cycle's `rdata` shows the location's previous contents.
- R7: When `bus_en`=0, no RAM location and no LED bit changes, and `rdata` keeps its value, whatever `bus_we`, `addr` and `wdata` are.
- R8: `rdata` always comes from the source selected by the address of the most recent enabled cycle. An I/O read issued directly after a RAM read, or the other way round, returns each source in turn with a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Bus cycle enable; qualifies reads and writes |
| bus_we | input | 1 | Write strobe, used when `bus_en` is high |
| addr | input | 8 | Byte address; bits 7:6 select the region |
| wdata | input | 8 | Write data |
| sw_in | input | 8 | Switch inputs, read through the I/O region |
| rdata | output | 8 | Registered read data, from RAM or from the switches |
| led_out | output | 8 | LED output register |

## Verification
Read-first behaviour is the hardest case to see from the ports. It only shows when a write lands on a location that already holds a known, different value, and the following cycle's output is then compared with the old value, not the new one. The bench first fills every RAM-region address with a computed pattern. It then writes a different value to several of those addresses, checks that the old value is returned in the following cycle, and reads the address again to confirm the new value. Back-to-back alternation between the I/O range and the RAM range, with the switches changing every cycle, checks that the registered select and the data move together.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;

    // Region selected by the two most significant address bits
    typedef enum logic [1:0] {
        RGN_LOW   = 2'b00,
        RGN_MIDLO = 2'b01,
        RGN_MIDHI = 2'b10,
        RGN_IO    = 2'b11
    } region_e;

    function automatic logic is_io_region(input logic [1:0] top_bits);
        return region_e'(top_bits) == RGN_IO;
    endfunction

endpackage

// File: rtl/mmio_region_decode.sv
module mmio_region_decode
    import mmio_dec_pkg::*;
(
    input  logic       bus_en,
    input  logic       bus_we,
    input  logic [1:0] top_bits,
    output logic       ram_we,
    output logic       led_we,
    output logic       io_hit
);

    always_comb begin
        io_hit = is_io_region(top_bits);
        ram_we = bus_en && bus_we && !io_hit;
        led_we = bus_en && bus_we && io_hit;
    end

endmodule

// File: rtl/mmio_byte_ram.sv
module mmio_byte_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Array update: no reset on the storage itself
    always_ff @(posedge clk) begin
        if (en && we) begin
            store[addr] <= wdata;
        end
    end

    // Read-first: output takes the pre-write contents
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en) begin
            rdata <= store[addr];
        end
    end

endmodule

// File: rtl/mmio_led_reg.sv
module mmio_led_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end

endmodule

// File: rtl/mmio_return_mux.sv
module mmio_return_mux #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              io_hit,
    input  logic [DATA_W-1:0] sw_in,
    input  logic [DATA_W-1:0] ram_q,
    output logic [DATA_W-1:0] rdata
);

    logic              io_sel_q;
    logic [DATA_W-1:0] sw_q;

    // Select and switch sample are captured in the issue cycle,
    // alongside the RAM's registered read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_sel_q <= 1'b0;
            sw_q     <= '0;
        end else if (en) begin
            io_sel_q <= io_hit;
            sw_q     <= sw_in;
        end
    end

    always_comb begin
        rdata = io_sel_q ? sw_q : ram_q;
    end

endmodule

// File: rtl/mmio_bus_decoder.sv
module mmio_bus_decoder #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] sw_in,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] led_out
);

    localparam int TOP_LSB = ADDR_W - 2;

    logic              ram_we;
    logic              led_we;
    logic              io_hit;
    logic [DATA_W-1:0] ram_q;

    mmio_region_decode u_decode (
        .bus_en  (bus_en),
        .bus_we  (bus_we),
        .top_bits(addr[ADDR_W-1:TOP_LSB]),
        .ram_we  (ram_we),
        .led_we  (led_we),
        .io_hit  (io_hit)
    );

    mmio_byte_ram #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (bus_en),
        .we   (ram_we),
        .addr (addr),
        .wdata(wdata),
        .rdata(ram_q)
    );

    mmio_led_reg #(
        .DATA_W(DATA_W)
    ) u_led (
        .clk  (clk),
        .rst_n(rst_n),
        .load (led_we),
        .din  (wdata),
        .dout (led_out)
    );

    mmio_return_mux #(
        .DATA_W(DATA_W)
    ) u_ret (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (bus_en),
        .io_hit(io_hit),
        .sw_in (sw_in),
        .ram_q (ram_q),
        .rdata (rdata)
    );

endmodule

// File: rtl/mmio_bus_decoder_chk.sv
module mmio_bus_decoder_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] sw_in,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] led_out,
    input logic              ram_we,
    input logic              led_we
);

    logic io_addr;
    assign io_addr = (addr[ADDR_W-1 -: 2] == 2'b11);

    AST_LED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && io_addr) |=> (led_out == $past(wdata))); // R3

    AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we && io_addr) |=> $stable(led_out)); // R4

    AST_IO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && io_addr) |=> (rdata == $past(sw_in))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> $stable(rdata)); // R7

    AST_NO_IO_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (!io_addr && bus_en)); // R3

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, led_we})); // R2

endmodule

bind mmio_bus_decoder mmio_bus_decoder_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_en (bus_en),
    .bus_we (bus_we),
    .addr   (addr),
    .wdata  (wdata),
    .sw_in  (sw_in),
    .rdata  (rdata),
    .led_out(led_out),
    .ram_we (ram_we),
    .led_we (led_we)
);

// File: tb/mmio_bus_decoder_tb.sv
module mmio_bus_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] sw_in = '0;
    logic [7:0] rdata;
    logic [7:0] led_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] model [256];
    logic [7:0] led_exp = '0;

    always #5 clk = ~clk;

    mmio_bus_decoder u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_en (bus_en),
        .bus_we (bus_we),
        .addr   (addr),
        .wdata  (wdata),
        .sw_in  (sw_in),
        .rdata  (rdata),
        .led_out(led_out)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) ^ 8'h5A);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive one bus cycle at the falling edge, then sample 2 ns after the rising edge
    task automatic cyc(input logic en, input logic we, input logic [7:0] a,
                       input logic [7:0] d, input logic [7:0] sw);
        @(negedge clk);
        bus_en = en;
        bus_we = we;
        addr   = a;
        wdata  = d;
        sw_in  = sw;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] hold;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 led in reset", led_out, 8'h00);
        chk("R1 rdata in reset", rdata, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk("R1 led after reset", led_out, 8'h00);
        chk("R1 rdata after reset", rdata, 8'h00);

        // R2/R4: fill the whole RAM region, LED must stay put
        for (int a = 0; a < 192; a++) begin
            cyc(1'b1, 1'b1, 8'(a), pat(a), 8'h00);
            model[a] = pat(a);
            chk("R4 led unchanged by RAM write", led_out, led_exp);
        end

        // R2/R8: read every RAM-region address back, one-cycle latency
        for (int a = 0; a < 192; a++) begin
            cyc(1'b1, 1'b0, 8'(a), 8'hEE, 8'hA5);
            chk("R2 RAM readback", rdata, model[a]);
        end

        // R3: every I/O address loads the LED register
        for (int a = 192; a < 256; a++) begin
            led_exp = 8'(a ^ 8'h3C);
            cyc(1'b1, 1'b1, 8'(a), led_exp, 8'h00);
            chk("R3 led load", led_out, led_exp);
        end

        // R3: RAM region intact after the I/O writes
        for (int a = 0; a < 192; a += 13) begin
            cyc(1'b1, 1'b0, 8'(a), 8'h00, 8'h00);
            chk("R3 RAM untouched by I/O write", rdata, model[a]);
        end

        // R5: switch sweep through the I/O window
        for (int s = 0; s < 256; s++) begin
            cyc(1'b1, 1'b0, 8'(8'hC0 | (s & 63)), 8'h00, 8'(s));
            chk("R5 switch read", rdata, 8'(s));
        end

        // R8: alternate I/O and RAM reads with switches changing each cycle
        for (int i = 0; i < 40; i++) begin
            if (i % 2 == 0) begin
                cyc(1'b1, 1'b0, 8'(8'hC0 + i), 8'h00, 8'(i * 11));
                chk("R8 alternating I/O read", rdata, 8'(i * 11));
            end else begin
                cyc(1'b1, 1'b0, 8'(i * 4), 8'h00, 8'(i * 11));
                chk("R8 alternating RAM read", rdata, model[i * 4]);
            end
        end

        // R6: read-first on overwrite, then the new value
        for (int a = 16; a < 192; a += 37) begin
            cyc(1'b1, 1'b1, 8'(a), ~model[a], 8'h00);
            chk("R6 read-first old data", rdata, model[a]);
            model[a] = ~model[a];
            cyc(1'b1, 1'b0, 8'(a), 8'h00, 8'h00);
            chk("R6 new data after write", rdata, model[a]);
        end

        // R7: disabled cycles change nothing and hold rdata
        cyc(1'b1, 1'b0, 8'h20, 8'h00, 8'h00);
        hold = rdata;
        chk("R7 setup read", hold, model[8'h20]);
        cyc(1'b0, 1'b1, 8'h20, 8'hFF, 8'h77);
        chk("R7 rdata held on disabled RAM write", rdata, hold);
        cyc(1'b0, 1'b1, 8'hD5, 8'h99, 8'h66);
        chk("R7 led held on disabled I/O write", led_out, led_exp);
        chk("R7 rdata held on disabled I/O cycle", rdata, hold);
        cyc(1'b1, 1'b0, 8'h20, 8'h00, 8'h00);
        chk("R7 RAM unchanged by disabled write", rdata, model[8'h20]);

        // R4: RAM write right after an LED load keeps the LED value
        led_exp = 8'hB4;
        cyc(1'b1, 1'b1, 8'hFF, led_exp, 8'h00);
        cyc(1'b1, 1'b1, 8'hBF, 8'h12, 8'h00);
        model[8'hBF] = 8'h12;
        chk("R4 led after boundary RAM write", led_out, led_exp);
        cyc(1'b1, 1'b0, 8'hBF, 8'h00, 8'h00);
        chk("R2 boundary address 0xBF", rdata, 8'h12);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule